// File: doc/BRIEF.md
# Processor Control-Pin Interrupt Conditioner

This block sits between the external control pins of a processor core and the core's pending-interrupt register. Every change on a pin arrives as one update: a pin index and the new level on that pin. The block remembers the last level it accepted for each of its seven pins. An update that repeats the stored level is dropped. A real change is turned, according to the rule for that pin, into a one-cycle set or clear request on one bit of the pending register, or into a change of the core's halt flag.

Updates use a valid/ready stream handshake. The block never applies back-pressure: `upd_ready` is high in every cycle, including reset. An update counts as transferred in any cycle where `upd_valid` is high and the clock rises. The upstream source may therefore present one update per clock. All outputs are registered. A transferred update shows its effect on the outputs after the next rising clock edge.

Pin index map: 0 hard reset, 1 soft reset, 2 checkstop, 3 time-base enable, 4 machine check, 5 external interrupt, 6 thermal. Pending-register bit map: 0 reset interrupt, 1 machine check, 2 external interrupt, 6 thermal. Bits 7 to 11 belong to internal timer sources, and this block never drives them.

Top module: `pin_event_conditioner`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every stored pin level to 0, clears `halted` and clears both masks. A level-1 update on any pin after reset therefore counts as a change.
- R2: An update whose level equals the stored level of its pin gives all-zero `pend_set` and `pend_clr`, and leaves `halted` and the stored levels unchanged.
- R3: A change on pin 5 (external interrupt) to level 1 sets bit 2 of `pend_set`. A change to level 0 sets bit 2 of `pend_clr`.
- R4: A change on pin 6 (thermal) to level 1 sets bit 6 of `pend_set`. A change to level 0 sets bit 6 of `pend_clr`.
- R5: A change on pin 1 (soft reset) to level 1 sets bit 0 of `pend_set`. A change to level 0 sets bit 0 of `pend_clr`.
- R6: A change on pin 4 (machine check) from 1 to 0 sets bit 1 of `pend_set`. A change from 0 to 1 gives all-zero masks. This pin never drives `pend_clr`.
- R7: After a change on pin 2 (checkstop), `halted` equals the new level: 1 halts the core and 0 resumes it. No other pin changes `halted`.
- R8: Changes on pin 0 (hard reset) and pin 3 (time-base enable) give all-zero masks and leave `halted` unchanged. The new level is only recorded.
- R9: An update with index 7 gives all-zero masks, leaves `halted` unchanged and modifies no stored level.
- R10: `upd_ready` is always 1. `pend_set` and `pend_clr` are set for exactly the one cycle after the edge at which the update was transferred, and they are zero after any cycle with `upd_valid` low.
- R11: In any cycle, at most one bit across `pend_set` and `pend_clr` together is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Pin update present |
| upd_ready | output | 1 | Always 1; the block accepts an update every cycle |
| upd_idx | input | 3 | Index of the pin being updated (0..6 defined) |
| upd_level | input | 1 | New level of that pin |
| pend_set | output | 12 | One-cycle set request per pending-register bit |
| pend_clr | output | 12 | One-cycle clear request per pending-register bit |
| halted | output | 1 | Core halted by checkstop |

## Verification
Every index from 0 to 7 is driven with the level sequence 1,1,0,0,1,0, followed by 0 again. This covers every pair of stored level and new level, including both directions of each edge, so the results separate the level, falling-edge, halt and ignore rules and show the repeat filter at work. Idle cycles with arbitrary index and level confirm that `upd_valid` gates every action.

A directed sequence sends an index-7 update between two updates to the external pin. If the out-of-range update corrupted a stored level, the filter result of the third update would change. A reset in the middle of a run is followed by level-1 updates, which shows the stored levels were cleared. A long pseudo-random stream then mixes all pins and levels back to back against the bench model.

// File: rtl/pin_cond_pkg.sv
package pin_cond_pkg;

  localparam int NUM_PINS  = 7;
  localparam int PIN_IDX_W = 3;
  localparam int PEND_W    = 12;

  // pin index map (neighbours drive pins by these numbers)
  localparam int PIN_HARD_RST = 0;
  localparam int PIN_SOFT_RST = 1;
  localparam int PIN_CHKSTOP  = 2;
  localparam int PIN_TB_EN    = 3;
  localparam int PIN_MCHK     = 4;
  localparam int PIN_EXT_IRQ  = 5;
  localparam int PIN_THERM    = 6;

  // pending-register bit positions (decoded by the pending register)
  localparam int PEND_RST_BIT   = 0;
  localparam int PEND_MCHK_BIT  = 1;
  localparam int PEND_EXT_BIT   = 2;
  localparam int PEND_THERM_BIT = 6;

  typedef enum logic [1:0] {
    RULE_IGNORE,
    RULE_LEVEL,
    RULE_FALL,
    RULE_HALT
  } pin_rule_e;

  typedef struct packed {
    logic                 hit;
    logic                 prev;
    logic                 level;
    logic [PIN_IDX_W-1:0] idx;
  } pin_change_t;

  function automatic pin_rule_e rule_of(input int pin);
    case (pin)
      PIN_SOFT_RST, PIN_EXT_IRQ, PIN_THERM: return RULE_LEVEL;
      PIN_MCHK:                             return RULE_FALL;
      PIN_CHKSTOP:                          return RULE_HALT;
      default:                              return RULE_IGNORE;
    endcase
  endfunction

  function automatic int target_of(input int pin);
    case (pin)
      PIN_SOFT_RST: return PEND_RST_BIT;
      PIN_MCHK:     return PEND_MCHK_BIT;
      PIN_EXT_IRQ:  return PEND_EXT_BIT;
      PIN_THERM:    return PEND_THERM_BIT;
      default:      return 0;
    endcase
  endfunction

endpackage

// File: rtl/pin_level_store.sv
module pin_level_store
  import pin_cond_pkg::*;
#(
  parameter int N_PINS = NUM_PINS,
  parameter int IDX_W  = PIN_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_level,
  output pin_change_t      chg
);

  logic [N_PINS-1:0] level_q;
  logic              in_range;
  logic              prev_lvl;

  assign in_range = (32'(upd_idx) < N_PINS);

  always_comb begin
    prev_lvl = 1'b0;
    for (int p = 0; p < N_PINS; p++) begin
      if (32'(upd_idx) == p) prev_lvl = level_q[p];
    end
  end

  assign chg.hit   = upd_valid && in_range && (prev_lvl != upd_level);
  assign chg.prev  = prev_lvl;
  assign chg.level = upd_level;
  assign chg.idx   = PIN_IDX_W'(upd_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
    end else if (chg.hit) begin
      for (int p = 0; p < N_PINS; p++) begin
        if (32'(upd_idx) == p) level_q[p] <= upd_level;
      end
    end
  end

endmodule

// File: rtl/pin_rule_decode.sv
module pin_rule_decode
  import pin_cond_pkg::*;
#(
  parameter int N_PINS = NUM_PINS,
  parameter int P_W    = PEND_W
) (
  input  pin_change_t     chg,
  output logic [P_W-1:0]  set_req,
  output logic [P_W-1:0]  clr_req,
  output logic            halt_on,
  output logic            halt_off
);

  logic [P_W-1:0]    set_arr [N_PINS];
  logic [P_W-1:0]    clr_arr [N_PINS];
  logic [N_PINS-1:0] on_v;
  logic [N_PINS-1:0] off_v;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    localparam pin_rule_e RULE = rule_of(p);
    logic sel;
    assign sel = chg.hit && (32'(chg.idx) == p);

    if (RULE == RULE_LEVEL) begin : g_level
      localparam int TGT = target_of(p);
      assign set_arr[p] = (sel &&  chg.level) ? (P_W'(1) << TGT) : '0;
      assign clr_arr[p] = (sel && !chg.level) ? (P_W'(1) << TGT) : '0;
      assign on_v[p]    = 1'b0;
      assign off_v[p]   = 1'b0;
    end else if (RULE == RULE_FALL) begin : g_fall
      localparam int TGT = target_of(p);
      assign set_arr[p] = (sel && chg.prev && !chg.level) ? (P_W'(1) << TGT) : '0;
      assign clr_arr[p] = '0;
      assign on_v[p]    = 1'b0;
      assign off_v[p]   = 1'b0;
    end else if (RULE == RULE_HALT) begin : g_halt
      assign set_arr[p] = '0;
      assign clr_arr[p] = '0;
      assign on_v[p]    = sel &&  chg.level;
      assign off_v[p]   = sel && !chg.level;
    end else begin : g_ignore
      assign set_arr[p] = '0;
      assign clr_arr[p] = '0;
      assign on_v[p]    = 1'b0;
      assign off_v[p]   = 1'b0;
    end
  end

  always_comb begin
    set_req = '0;
    clr_req = '0;
    for (int p = 0; p < N_PINS; p++) begin
      set_req = set_req | set_arr[p];
      clr_req = clr_req | clr_arr[p];
    end
  end

  assign halt_on  = |on_v;
  assign halt_off = |off_v;

endmodule

// File: rtl/pin_event_conditioner.sv
module pin_event_conditioner
  import pin_cond_pkg::*;
#(
  parameter int N_PINS = NUM_PINS,
  parameter int IDX_W  = PIN_IDX_W,
  parameter int P_W    = PEND_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_level,
  output logic [P_W-1:0]   pend_set,
  output logic [P_W-1:0]   pend_clr,
  output logic             halted
);

  pin_change_t    chg;
  logic [P_W-1:0] set_req;
  logic [P_W-1:0] clr_req;
  logic           halt_on;
  logic           halt_off;

  assign upd_ready = 1'b1;

  pin_level_store #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_idx   (upd_idx),
    .upd_level (upd_level),
    .chg       (chg)
  );

  pin_rule_decode #(.N_PINS(N_PINS), .P_W(P_W)) u_decode (
    .chg      (chg),
    .set_req  (set_req),
    .clr_req  (clr_req),
    .halt_on  (halt_on),
    .halt_off (halt_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_set <= '0;
      pend_clr <= '0;
      halted   <= 1'b0;
    end else begin
      pend_set <= set_req;
      pend_clr <= clr_req;
      if (halt_on)       halted <= 1'b1;
      else if (halt_off) halted <= 1'b0;
    end
  end

endmodule

// File: rtl/pin_event_conditioner_chk.sv
module pin_event_conditioner_chk
  import pin_cond_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 upd_valid,
  input logic [PIN_IDX_W-1:0] upd_idx,
  input logic                 upd_level,
  input logic [PEND_W-1:0]    pend_set,
  input logic [PEND_W-1:0]    pend_clr,
  input logic                 halted
);

  p_one_bit_r11: assert property (@(posedge clk) disable iff (rst)
    $countones({pend_set, pend_clr}) <= 1);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> (pend_set == '0 && pend_clr == '0 && $stable(halted)));

  p_out_of_range_r9: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && 32'(upd_idx) >= NUM_PINS)
      |=> (pend_set == '0 && pend_clr == '0 && $stable(halted)));

  p_passive_pins_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (32'(upd_idx) == PIN_HARD_RST || 32'(upd_idx) == PIN_TB_EN))
      |=> (pend_set == '0 && pend_clr == '0 && $stable(halted)));

  p_halt_follows_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && 32'(upd_idx) == PIN_CHKSTOP) |=> (halted == $past(upd_level)));

  p_mchk_rise_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && 32'(upd_idx) == PIN_MCHK && upd_level)
      |=> (pend_set == '0 && pend_clr == '0));

  p_ext_no_clear_on_high_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && 32'(upd_idx) == PIN_EXT_IRQ && upd_level)
      |=> (pend_clr == '0));

  p_therm_no_set_on_low_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && 32'(upd_idx) == PIN_THERM && !upd_level)
      |=> (pend_set == '0));

endmodule

bind pin_event_conditioner pin_event_conditioner_chk u_chk (.*);

// File: tb/pin_event_conditioner_bench.sv
`timescale 1ns/100ps
module pin_event_conditioner_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        upd_valid;
  logic        upd_ready;
  logic [2:0]  upd_idx;
  logic        upd_level;
  logic [11:0] pend_set;
  logic [11:0] pend_clr;
  logic        halted;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [6:0] ref_st;
  logic       ref_halt;

  always #2.5 clk = ~clk;

  pin_event_conditioner u_pin_event_conditioner (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_ready (upd_ready),
    .upd_idx   (upd_idx),
    .upd_level (upd_level),
    .pend_set  (pend_set),
    .pend_clr  (pend_clr),
    .halted    (halted)
  );

  function automatic string req_of(input logic v, input int idx, input logic chg);
    if (!v) return "R10";
    if (idx >= 7) return "R9";
    if (!chg) return "R2";
    case (idx)
      1: return "R5";
      2: return "R7";
      4: return "R6";
      5: return "R3";
      6: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [11:0] es,
                         input logic [11:0] ec, input logic eh);
    vectors++;
    if (pend_set !== es || pend_clr !== ec || halted !== eh || upd_ready !== 1'b1) begin
      miscompares++;
      $display("FAIL %s set=%h/%h clr=%h/%h halted=%b/%b ready=%b/1 (actual/expected)",
               tag, pend_set, es, pend_clr, ec, halted, eh, upd_ready);
    end
  endtask

  // called at a negedge; drives, waits one edge, checks at the next negedge
  task automatic apply(input logic v, input int idx, input logic l, input string force_tag);
    logic [11:0] es = '0;
    logic [11:0] ec = '0;
    logic        eh = ref_halt;
    logic        chg = 1'b0;
    string       tag;
    if (v && idx < 7) chg = (ref_st[idx] != l);
    if (chg) begin
      case (idx)
        1: if (l) es[0] = 1'b1; else ec[0] = 1'b1;
        2: eh = l;
        4: if (!l) es[1] = 1'b1;
        5: if (l) es[2] = 1'b1; else ec[2] = 1'b1;
        6: if (l) es[6] = 1'b1; else ec[6] = 1'b1;
        default: ;
      endcase
      ref_st[idx] = l;
    end
    ref_halt = eh;
    tag = (force_tag != "") ? force_tag : req_of(v, idx, chg);
    upd_valid = v;
    upd_idx   = 3'(idx);
    upd_level = l;
    @(posedge clk);
    @(negedge clk);
    compare(tag, es, ec, eh);
    // one-cycle pulse check for the following idle cycle
    upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    upd_valid = 1'b0;
    upd_idx = '0;
    upd_level = 1'b0;
    repeat (2) @(negedge clk);
    ref_st = '0;
    ref_halt = 1'b0;
    compare("R1", 12'h000, 12'h000, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic        seq [7] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    @(negedge clk);
    do_reset();

    // R10: idle cycles with arbitrary index/level
    for (int i = 0; i < 16; i++) apply(1'b0, i % 8, 1'(i / 8), "");

    // exhaustive transition sweep over every index
    for (int idx = 0; idx < 8; idx++)
      for (int k = 0; k < 7; k++) apply(1'b1, idx, seq[k], "");

    // R6: falling edge then idle confirms single-cycle pulse (R10)
    apply(1'b1, 4, 1'b1, "");
    apply(1'b1, 4, 1'b0, "");
    apply(1'b0, 4, 1'b0, "R10");

    // R9: out-of-range update must not corrupt a stored level
    apply(1'b1, 5, 1'b1, "");
    apply(1'b1, 7, 1'b0, "");
    apply(1'b1, 5, 1'b1, "R9");
    apply(1'b1, 7, 1'b1, "");
    apply(1'b1, 5, 1'b0, "R9");

    // R1: mid-run reset clears stored levels and halt
    apply(1'b1, 2, 1'b1, "");
    apply(1'b1, 6, 1'b1, "");
    apply(1'b1, 1, 1'b1, "");
    do_reset();
    apply(1'b1, 6, 1'b1, "R1");
    apply(1'b1, 1, 1'b1, "R1");
    apply(1'b1, 2, 1'b1, "R1");

    // back-to-back pseudo-random stream (R11 and all rules)
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      upd_valid = lfsr[0] | lfsr[5];
      apply(lfsr[0] | lfsr[5], int'(lfsr[3:1]), lfsr[4], "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule